// File: doc/BRIEF.md
# Dual-Register Selectable Logic Comparator

The block holds two independent serial-in, parallel-out shift registers, called channel X and channel Y. Each channel has its own serial data bit, its own shift strobe and its own synchronous clear. The bits in the two registers are combined bit by bit through one of four selections: a constant zero, the Y channel, the X channel, or bitwise equivalence (XNOR) of X and Y. A final invert input complements every selected bit. Together these give eight operations: all zeros, all ones, X, not X, Y, not Y, XNOR and XOR. The result is registered and appears on the clock edge after the inputs it depends on.

Data enters one serial bit per strobe. The block never applies back-pressure, so every strobe is taken in the cycle it is asserted and there is no ready signal. The result is a plain registered output that is refreshed every cycle and has no valid qualifier. A typical use is to load two captured words one bit at a time and then compare or select between them with a single 3-bit operation code.

Top module: `twin_sreg_logic_cmp`

## Requirements
- R1: While `rst` is high, the next clock edge clears `result` and both shift registers to zero.
- R2: On an edge where a channel's shift strobe is high and its clear is low, that channel's serial bit enters register bit 0, each bit k moves to bit k+1, and the top bit is discarded. Result bit n is taken from register bit n of each channel.
- R3: On an edge where a channel's strobe and clear are both low, that channel's register keeps its value.
- R4: A channel's clear is synchronous and zeroes only that channel's register. It wins over the same channel's shift strobe, and the other channel's register is unaffected.
- R5: Selection code `sel_code` = 2'b00 yields all zeros when `invert` is 0, and all ones when `invert` is 1.
- R6: `sel_code` = 2'b01 passes the Y register and `sel_code` = 2'b10 passes the X register, bit for bit.
- R7: `sel_code` = 2'b11 yields bitwise XNOR of X and Y when `invert` is 0, and bitwise XOR when `invert` is 1.
- R8: `invert` = 1 complements every result bit, for every selection code.
- R9: `result` updates on the clock edge that samples `sel_code`, `invert` and the register contents as they were just before that edge. A shift therefore appears in `result` one edge after the edge that performed it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Global synchronous reset, active high |
| x_ser_in | input | 1 | Serial data bit for channel X |
| x_shift_en | input | 1 | Shift strobe for channel X |
| x_clr | input | 1 | Synchronous clear for channel X, active high |
| y_ser_in | input | 1 | Serial data bit for channel Y |
| y_shift_en | input | 1 | Shift strobe for channel Y |
| y_clr | input | 1 | Synchronous clear for channel Y, active high |
| sel_code | input | 2 | Selection: 00 zero, 01 Y, 10 X, 11 XNOR |
| invert | input | 1 | Complements all result bits when high |
| result | output | WIDTH (4) | Registered combined result |

## Verification
A single 1 is walked through channel X with the X selection active. The moving bit shows the entry position and the shift direction, and it would expose any reversal of bit order between the registers and the result. The fixed pair X=1010 and Y=0110 holds all four bit combinations, so a sweep over the eight operations with that pair tells every selection and the invert apart in one word each. Clears that coincide with shift strobes, idle stretches and an invert toggled every cycle separate the clear priority, the hold behaviour and the one-edge latency. A long random run with all strobes, clears and codes mixed then checks every cycle against a model of both registers.

// File: rtl/twin_cmp_pkg.sv
package twin_cmp_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ZERO = 2'b00,
    SEL_Y    = 2'b01,
    SEL_X    = 2'b10,
    SEL_EQ   = 2'b11
  } sel_e;
endpackage

// File: rtl/twin_cmp_sreg.sv
module twin_cmp_sreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             shift_en,
  input  logic             clr,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_next;

  generate
    if (WIDTH == 1) begin : g_single
      always_comb q_next = ser_in;
    end else begin : g_multi
      always_comb q_next = {q[WIDTH-2:0], ser_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= '0;
    else if (shift_en)
      q <= q_next;
  end

  // R4: clear wins over shift
  p_clr_wins_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

  // R2: new bit lands in bit 0
  p_shift_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clr) |=> (q[0] == $past(ser_in)));

  generate
    if (WIDTH > 1) begin : g_move_chk
      // R2: bits move one place upward
      p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clr) |=> (q[WIDTH-1:1] == $past(q[WIDTH-2:0])));
    end
  endgenerate

  // R3: idle register holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !clr) |=> $stable(q));

endmodule

// File: rtl/twin_cmp_bitop.sv
module twin_cmp_bitop
  import twin_cmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  sel_e             sel,
  input  logic             invert,
  output logic [WIDTH-1:0] z
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic pick;
      always_comb begin
        unique case (sel)
          SEL_ZERO: pick = 1'b0;
          SEL_Y:    pick = y[i];
          SEL_X:    pick = x[i];
          SEL_EQ:   pick = ~(x[i] ^ y[i]);
          default:  pick = 1'b0;
        endcase
        z[i] = pick ^ invert;
      end
    end
  endgenerate

endmodule

// File: rtl/twin_sreg_logic_cmp.sv
module twin_sreg_logic_cmp
  import twin_cmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             x_ser_in,
  input  logic             x_shift_en,
  input  logic             x_clr,
  input  logic             y_ser_in,
  input  logic             y_shift_en,
  input  logic             y_clr,
  input  logic [SEL_W-1:0] sel_code,
  input  logic             invert,
  output logic [WIDTH-1:0] result
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] x_q;
  logic [WIDTH-1:0] y_q;
  logic [WIDTH-1:0] comb_z;
  sel_e             sel;

  assign sel = sel_e'(sel_code);

  twin_cmp_sreg #(.WIDTH(WIDTH)) u_sreg_x (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (x_ser_in),
    .shift_en (x_shift_en),
    .clr      (x_clr),
    .q        (x_q)
  );

  twin_cmp_sreg #(.WIDTH(WIDTH)) u_sreg_y (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (y_ser_in),
    .shift_en (y_shift_en),
    .clr      (y_clr),
    .q        (y_q)
  );

  twin_cmp_bitop #(.WIDTH(WIDTH)) u_bitop (
    .x      (x_q),
    .y      (y_q),
    .sel    (sel),
    .invert (invert),
    .z      (comb_z)
  );

  always_ff @(posedge clk) begin
    if (rst)
      result <= '0;
    else
      result <= comb_z;
  end

  // R1: reset clears the result
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (result == '0));

  // R5: constant code gives zeros or ones
  p_const_code_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b00) |=> (result == ($past(invert) ? ALL_ONES : '0)));

  // R6: pass X channel
  p_pass_x_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b10 && !invert) |=> (result == $past(x_q)));

  // R6: pass Y channel
  p_pass_y_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b01 && !invert) |=> (result == $past(y_q)));

  // R7: equivalence code with invert gives XOR
  p_xor_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b11 && invert) |=> (result == $past(x_q ^ y_q)));

  // R4: clearing X leaves an idle Y alone
  p_clear_isolated_r4: assert property (@(posedge clk) disable iff (rst)
    (x_clr && !y_clr && !y_shift_en) |=> $stable(y_q));

endmodule

// File: tb/twin_sreg_logic_cmp_tb.sv
module twin_sreg_logic_cmp_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         x_ser_in, x_shift_en, x_clr;
  logic         y_ser_in, y_shift_en, y_clr;
  logic [1:0]   sel_code;
  logic         invert;
  logic [W-1:0] result;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] mx, my;

  always #10 clk = ~clk;

  twin_sreg_logic_cmp #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst),
    .x_ser_in(x_ser_in), .x_shift_en(x_shift_en), .x_clr(x_clr),
    .y_ser_in(y_ser_in), .y_shift_en(y_shift_en), .y_clr(y_clr),
    .sel_code(sel_code), .invert(invert), .result(result)
  );

  function automatic logic [W-1:0] ref_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [1:0] c, input logic inv);
    logic [W-1:0] r;
    case (c)
      2'b00:   r = '0;
      2'b01:   r = y;
      2'b10:   r = x;
      default: r = ~(x ^ y);
    endcase
    return inv ? ~r : r;
  endfunction

  function automatic string auto_tag(input logic [1:0] c, input logic inv);
    string t;
    t = (c == 2'b00) ? "R5" : (c == 2'b11) ? "R7" : "R6";
    if (inv) t = {t, "+R8"};
    return t;
  endfunction

  task automatic drive(input logic r, input logic xs, input logic xe, input logic xc,
                       input logic ys, input logic ye, input logic yc,
                       input logic [1:0] c, input logic inv, input string tag);
    @(negedge clk);
    rst = r; x_ser_in = xs; x_shift_en = xe; x_clr = xc;
    y_ser_in = ys; y_shift_en = ye; y_clr = yc; sel_code = c; invert = inv;
    exp_q.push_back(r ? '0 : ref_op(mx, my, c, inv));
    tag_q.push_back(tag == "" ? auto_tag(c, inv) : tag);
    if (r || xc) mx = '0; else if (xe) mx = {mx[W-2:0], xs};
    if (r || yc) my = '0; else if (ye) my = {my[W-2:0], ys};
  endtask

  task automatic load_pair(input logic [W-1:0] xv, input logic [W-1:0] yv);
    for (int k = W-1; k >= 0; k--)
      drive(1'b0, xv[k], 1'b1, 1'b0, yv[k], 1'b1, 1'b0, 2'b11, 1'b0, "R2");
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (result !== e) begin
          n_fails++;
          $display("FAIL %s: result=%b expected=%b at %0t", t, result, e, $time);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    mx = '0; my = '0;
    rst = 1'b1; x_ser_in = 0; x_shift_en = 0; x_clr = 0;
    y_ser_in = 0; y_shift_en = 0; y_clr = 0; sel_code = 2'b11; invert = 1'b1;

    // R1: reset forces zero even with an all-ones operation
    repeat (3) drive(1'b1, 1, 1, 0, 1, 1, 0, 2'b00, 1'b1, "R1");

    // R2: walk a single 1 through X, observed on the X selection
    drive(1'b0, 1, 1, 0, 0, 0, 0, 2'b10, 1'b0, "R2");
    for (int k = 0; k < W + 1; k++)
      drive(1'b0, 0, 1, 0, 0, 0, 0, 2'b10, 1'b0, "R2");

    // fixed pair X=1010, Y=0110 and full sweep of eight operations
    load_pair(4'b1010, 4'b0110);
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 2; v++)
        drive(1'b0, 0, 0, 0, 0, 0, 0, c[1:0], v[0], "");

    // R3: idle hold across several cycles
    repeat (4) drive(1'b0, 1, 0, 0, 1, 0, 0, 2'b11, 1'b1, "R3");

    // R9: invert toggled each cycle shows single-edge latency
    for (int k = 0; k < 6; k++)
      drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b10, k[0], "R9");
    // R9: shift visible one edge after it happens
    drive(1'b0, 1, 1, 0, 0, 0, 0, 2'b10, 1'b0, "R9");
    drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b10, 1'b0, "R9");

    // R4: clear X with a shift strobe, Y must stay intact
    drive(1'b0, 1, 1, 1, 0, 0, 0, 2'b01, 1'b0, "R4");
    drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b10, 1'b0, "R4");
    drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b01, 1'b0, "R4");
    load_pair(4'b1100, 4'b0011);
    drive(1'b0, 0, 0, 0, 1, 1, 1, 2'b10, 1'b0, "R4");
    drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b10, 1'b0, "R4");
    drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b01, 1'b1, "R4");

    // random traffic over all codes
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive(1'b0, r[0], r[1], (r[7:4] == 4'd0), r[2], r[3], (r[11:8] == 4'd0),
            r[13:12], r[14], "");
    end

    // R1: mid-run reset
    drive(1'b1, 1, 1, 0, 1, 1, 0, 2'b01, 1'b1, "R1");
    drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b10, 1'b0, "R1");
    drive(1'b0, 0, 0, 0, 0, 0, 0, 2'b01, 1'b0, "R1");

    repeat (3) @(posedge clk);
    #5;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule